// File: doc/BRIEF.md
# Asynchronous Bus Strobe Pulse Generator

This block sits on the boundary between an external processor-style bus and the on-chip system clock. The three bus control strobes (write, read and address-latch enable) arrive with no timing relation to `clk`. Each one passes through its own chain of flip-flops clocked by `clk`. Only then is a rising-edge detector applied to it, and that detector emits a pulse exactly one clock wide for every assertion of the strobe.

The write pulse is then compared against the register address bus. A bus write aimed at one fixed register address produces a single-cycle "register written" flag that downstream logic can use as an enable. The synchronizer depth, the address width, the target address and whether the edge pulse is registered are all parameters. Strobes are expected to stay high for at least two clock periods, and the address is expected to stay stable for the whole synchronization delay.

Top module: `bus_strobe_pulser`

## Requirements
- R1: Each synchronized level output follows its raw strobe, delayed by SYNC_STAGES-1 clock edges. With the default of 2 stages, the value present at edge n appears on the output after edge n+1.
- R2: A synchronous active-high `rst` clears every stage. While reset is held, and in the first cycles after it is released, all outputs are 0 with no spurious pulse.
- R3: An edge pulse is never high in two consecutive cycles.
- R4: The edge pulse rises when the synchronized level rises. With REG_PULSE=1 (the default) this happens one cycle after the level rises. With REG_PULSE=0 it happens in the same cycle.
- R5: A strobe held high for many cycles produces exactly one pulse on its edge output.
- R6: `reg_written_o` goes high for one cycle, one edge after the write pulse, when the address sampled in the cycle of the pulse equals TARGET_ADDR (default 8'h5A).
- R7: `reg_written_o` stays 0 when the address differs from TARGET_ADDR or when there is no write pulse. Read and address-latch pulses never set it.
- R8: The read and address-latch strobes have the same timing as the write strobe and are independent of each other and of the write strobe.
- R9: `reg_written_o` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_i | input | 1 | Raw asynchronous write strobe |
| bus_rd_i | input | 1 | Raw asynchronous read strobe |
| bus_ale_i | input | 1 | Raw asynchronous address-latch strobe |
| bus_addr_i | input | ADDR_W | Register address bus |
| wr_level_o | output | 1 | Synchronized write level |
| rd_level_o | output | 1 | Synchronized read level |
| ale_level_o | output | 1 | Synchronized address-latch level |
| wr_pulse_o | output | 1 | One-cycle pulse on each write assertion |
| rd_pulse_o | output | 1 | One-cycle pulse on each read assertion |
| ale_pulse_o | output | 1 | One-cycle pulse on each address-latch assertion |
| reg_written_o | output | 1 | One-cycle flag for a write to TARGET_ADDR |

## Verification
With default parameters, a strobe level present at edge n shows on its level output after edge n+1. Its pulse covers the cycle after edge n+2, and the qualified write flag follows after edge n+3, using the address present at that edge.

The bench records every raw strobe and address value at each rising edge in shift histories. It derives each expected output from the history entry at the matching depth and compares at the falling edge, after all registers have settled. Directed phases then count the pulses over a long-held strobe and over writes to a wrong address.

// File: rtl/strobe_pkg.sv
package strobe_pkg;
  localparam int NUM_STROBES = 3;

  typedef enum int {
    STB_WR  = 0,
    STB_RD  = 1,
    STB_ALE = 2
  } strobe_idx_e;
endpackage

// File: rtl/strobe_sync.sv
// Flip-flop chain that brings one asynchronous level into the clk domain.
module strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic sync_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= async_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[LAST-1:0], async_i};
      end
    end
  endgenerate

  assign sync_o = chain_q[LAST];
endmodule

// File: rtl/strobe_edge.sv
// Synchronizer, one delay stage and rising-edge pulse for a single strobe.
module strobe_edge #(
  parameter int STAGES    = 2,
  parameter bit REG_PULSE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_i,
  output logic level_o,
  output logic pulse_o
);
  logic level_dly_q;
  logic rise;

  strobe_sync #(.STAGES(STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (raw_i),
    .sync_o  (level_o)
  );

  always_ff @(posedge clk) begin
    if (rst) level_dly_q <= 1'b0;
    else     level_dly_q <= level_o;
  end

  assign rise = level_o & ~level_dly_q;

  generate
    if (REG_PULSE) begin : g_reg
      logic pulse_q;
      always_ff @(posedge clk) begin
        if (rst) pulse_q <= 1'b0;
        else     pulse_q <= rise;
      end
      assign pulse_o = pulse_q;

      AST_PULSE_LATE_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(level_o) |=> pulse_o); // R4
    end else begin : g_comb
      assign pulse_o = rise;

      AST_PULSE_SAME_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(level_o) |-> pulse_o); // R4
    end
  endgenerate

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pulse_o |=> !pulse_o); // R3
endmodule

// File: rtl/bus_strobe_pulser.sv
module bus_strobe_pulser
  import strobe_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] TARGET_ADDR = ADDR_W'('h5A),
  parameter int                SYNC_STAGES = 2,
  parameter bit                REG_PULSE   = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic              bus_ale_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  output logic              wr_level_o,
  output logic              rd_level_o,
  output logic              ale_level_o,
  output logic              wr_pulse_o,
  output logic              rd_pulse_o,
  output logic              ale_pulse_o,
  output logic              reg_written_o
);
  logic [NUM_STROBES-1:0] raw_vec;
  logic [NUM_STROBES-1:0] level_vec;
  logic [NUM_STROBES-1:0] pulse_vec;
  logic                   written_q;

  assign raw_vec[STB_WR]  = bus_wr_i;
  assign raw_vec[STB_RD]  = bus_rd_i;
  assign raw_vec[STB_ALE] = bus_ale_i;

  generate
    for (genvar i = 0; i < NUM_STROBES; i++) begin : g_strobe
      strobe_edge #(
        .STAGES    (SYNC_STAGES),
        .REG_PULSE (REG_PULSE)
      ) u_edge (
        .clk     (clk),
        .rst     (rst),
        .raw_i   (raw_vec[i]),
        .level_o (level_vec[i]),
        .pulse_o (pulse_vec[i])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) written_q <= 1'b0;
    else     written_q <= pulse_vec[STB_WR] && (bus_addr_i == TARGET_ADDR);
  end

  assign wr_level_o    = level_vec[STB_WR];
  assign rd_level_o    = level_vec[STB_RD];
  assign ale_level_o   = level_vec[STB_ALE];
  assign wr_pulse_o    = pulse_vec[STB_WR];
  assign rd_pulse_o    = pulse_vec[STB_RD];
  assign ale_pulse_o   = pulse_vec[STB_ALE];
  assign reg_written_o = written_q;

  AST_FLAG_NEEDS_MATCH: assert property (@(posedge clk) disable iff (rst)
    reg_written_o |-> ($past(wr_pulse_o) && ($past(bus_addr_i) == TARGET_ADDR))); // R6

  AST_FLAG_SINGLE: assert property (@(posedge clk) disable iff (rst)
    reg_written_o |=> !reg_written_o); // R9

  AST_NO_FLAG_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (rst)
    !wr_pulse_o |=> !reg_written_o); // R7
endmodule

// File: tb/bus_strobe_pulser_bench.sv
module bus_strobe_pulser_bench;
  localparam int          ADDR_W = 8;
  localparam logic [7:0]  TARGET = 8'h5A;
  localparam int          S      = 2;
  localparam int          R      = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr = 1'b0, rd = 1'b0, ale = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic wr_lv, rd_lv, ale_lv, wr_p, rd_p, ale_p, flag;

  int n_tests = 0;
  int n_fail  = 0;
  bit model_on = 1'b0;

  // index i holds the value seen at the edge i cycles back (0 = latest)
  logic [7:0] h_wr = '0, h_rd = '0, h_ale = '0;
  logic [ADDR_W-1:0] last_addr = '0;

  always #5 clk = ~clk;

  bus_strobe_pulser #(
    .ADDR_W(ADDR_W), .TARGET_ADDR(TARGET), .SYNC_STAGES(S), .REG_PULSE(1'b1)
  ) u_bus_strobe_pulser (
    .clk(clk), .rst(rst), .bus_wr_i(wr), .bus_rd_i(rd), .bus_ale_i(ale),
    .bus_addr_i(addr), .wr_level_o(wr_lv), .rd_level_o(rd_lv),
    .ale_level_o(ale_lv), .wr_pulse_o(wr_p), .rd_pulse_o(rd_p),
    .ale_pulse_o(ale_p), .reg_written_o(flag)
  );

  always @(posedge clk) begin
    if (rst) begin
      h_wr <= '0; h_rd <= '0; h_ale <= '0; last_addr <= addr;
    end else begin
      h_wr  <= {h_wr[6:0], wr};
      h_rd  <= {h_rd[6:0], rd};
      h_ale <= {h_ale[6:0], ale};
      last_addr <= addr;
    end
  end

  function automatic logic exp_level(logic [7:0] h);
    return h[S-1];
  endfunction

  function automatic logic exp_pulse(logic [7:0] h);
    return h[S-1+R] & ~h[S+R];
  endfunction

  function automatic logic exp_flag(logic [7:0] h, logic [ADDR_W-1:0] a);
    return h[S+R] & ~h[S+R+1] & (a == TARGET);
  endfunction

  task automatic chk(string req, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %b expected %b", req, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (model_on && !rst) begin
      chk("R1 wr level",  wr_lv,  exp_level(h_wr));
      chk("R8 rd level",  rd_lv,  exp_level(h_rd));
      chk("R8 ale level", ale_lv, exp_level(h_ale));
      chk("R4 wr pulse",  wr_p,   exp_pulse(h_wr));
      chk("R8 rd pulse",  rd_p,   exp_pulse(h_rd));
      chk("R8 ale pulse", ale_p,  exp_pulse(h_ale));
      chk("R6 flag",      flag,   exp_flag(h_wr, last_addr));
    end
  end

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 10);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int pulses;
    int flags;
    void'($urandom(32'd1234));
    wr = 1'b1; rd = 1'b1; ale = 1'b1; addr = TARGET;
    cycles(8);
    // R2: outputs clear while reset held with strobes high
    chk("R2 reset wr_level", wr_lv, 1'b0);
    chk("R2 reset wr_pulse", wr_p, 1'b0);
    chk("R2 reset rd_pulse", rd_p, 1'b0);
    chk("R2 reset flag", flag, 1'b0);
    wr = 1'b0; rd = 1'b0; ale = 1'b0;
    cycles(2);
    rst = 1'b0;
    model_on = 1'b1;
    cycles(4);
    chk("R2 no pulse after reset", wr_p | rd_p | ale_p | flag, 1'b0);

    // R5: long write to target gives one pulse and one flag (R6, R9)
    pulses = 0; flags = 0;
    addr = TARGET; wr = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (wr_p) pulses++;
      if (flag) flags++;
    end
    wr = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (wr_p) pulses++;
      if (flag) flags++;
    end
    chk("R5 one pulse for long strobe", pulses == 1, 1'b1);
    chk("R9 one flag per write", flags == 1, 1'b1);

    // R7: write to a different address, plus reads and ALE at target
    flags = 0;
    addr = TARGET ^ 8'h01; wr = 1'b1;
    for (int i = 0; i < 8; i++) begin @(negedge clk); if (flag) flags++; end
    wr = 1'b0; addr = TARGET; rd = 1'b1; ale = 1'b1;
    for (int i = 0; i < 8; i++) begin @(negedge clk); if (flag) flags++; end
    rd = 1'b0; ale = 1'b0;
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (flag) flags++; end
    chk("R7 no flag on mismatch or read", flags == 0, 1'b1);

    // Random phase: R1, R3, R4, R6, R8 via model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      if ($urandom_range(3) == 0) wr  = ~wr;
      if ($urandom_range(3) == 0) rd  = ~rd;
      if ($urandom_range(3) == 0) ale = ~ale;
      addr = ($urandom_range(1) == 0) ? TARGET : ADDR_W'($urandom);
    end
    cycles(8);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule